// File: doc/BRIEF.md
# Timer Compare Output Unit

This unit watches a free-running timer value and compares it against a programmable compare value on every clock cycle. When the two are equal and the unit is armed, it performs an action chosen by a 4-bit mode register on an output latch that drives a pin: it drives the latch high, drives it low, toggles it, or leaves it alone and only raises the interrupt flag. Whenever a compare action fires, the interrupt flag is set. The flag stays set until software clears it.

Control is held in a small state machine with three states. ST_OFF covers any mode that is not a compare code. ST_ARMED means the unit waits for equality. ST_HELD means an action has fired and equality still persists. The transitions are as follows. T_ENABLE takes ST_OFF to ST_ARMED when the registered mode is a compare code. T_FIRE takes ST_ARMED to ST_HELD on equality and performs the action. T_REARM takes ST_HELD back to ST_ARMED on the first cycle of inequality. T_DISABLE takes ST_ARMED or ST_HELD to ST_OFF when the registered mode is no longer a compare code. Writing the all-zero mode forces the output latch low. This latch belongs to the unit and is distinct from any general port data latch. The timer, the pin direction, the port data latch and interrupt masking are outside this block.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset the compare value is 0, the mode is 0000 (off), the state is ST_OFF, and both out_latch and irq_flag are 0.
- R2: With cmp_wr_en high at a clock edge, cmp_wr_data is loaded into the compare register. From the next cycle onward, that register is compared with timer_val.
- R3: In a cycle where the unit is in ST_ARMED and the compare value equals timer_val, the action takes effect at that cycle's closing edge. The flag is set at the same edge. Mode 1000 drives out_latch to 1, mode 1001 drives it to 0, and mode 1011 inverts it.
- R4: In mode 1010, a match sets irq_flag and leaves out_latch unchanged.
- R5: A mode write of 0000 forces out_latch to 0 at that edge. This overrides any action in the same cycle and leaves irq_flag untouched.
- R6: An action fires only once per period of equality. Further equal cycles do nothing, and the unit re-arms after the first unequal cycle.
- R7: irq_flag stays set until flag_clr is high at an edge. When a match and flag_clr occur in the same cycle, the flag ends up set.
- R8: A mode code outside 1000 to 1011 disables matching. After a compare code is written, the unit is armed from the second edge after the write. A nonzero non-compare code leaves out_latch at its present value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timer_val | input | 16 | Current timer value |
| cmp_wr_en | input | 1 | Load strobe for the compare register |
| cmp_wr_data | input | 16 | New compare value |
| mode_wr_en | input | 1 | Load strobe for the mode register |
| mode_wr_data | input | 4 | New mode code |
| flag_clr | input | 1 | Clears the interrupt flag |
| out_latch | output | 1 | Compare output latch driving the pin |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The scoreboard holds the timer on the compare value for several cycles. A unit lacking the held state would fire again, re-toggling the pin or setting a flag that had just been cleared. It asserts a match and flag_clr together; a design with the wrong priority would lose the interrupt. It writes the zero mode while the latch is high and checks that a nonzero undefined code does not do the same, which catches a force that is missing or applied too widely. It runs the interrupt-only mode with the latch high, so a design that drives the pin in that mode would show a changed output.

// File: rtl/cmpo_pkg.sv
package cmpo_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF  = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_HIGH = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_LOW  = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_IRQ  = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_TOG  = 4'b1011;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMED,
        ST_HELD
    } cmp_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_HIGH,
        ACT_LOW,
        ACT_TOGGLE,
        ACT_IRQ
    } cmp_act_e;

    function automatic cmp_act_e decode_mode(input logic [MODE_W-1:0] m);
        cmp_act_e a;
        case (m)
            MODE_HIGH: a = ACT_HIGH;
            MODE_LOW:  a = ACT_LOW;
            MODE_IRQ:  a = ACT_IRQ;
            MODE_TOG:  a = ACT_TOGGLE;
            default:   a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cmpo_match.sv
module cmpo_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] tmr_val,
    output logic         eq
);
    logic [W-1:0] bit_eq;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_eq[i] = ~(cmp_val[i] ^ tmr_val[i]);
    end

    assign eq = &bit_eq;
endmodule

// File: rtl/cmpo_fsm.sv
module cmpo_fsm
    import cmpo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armable,
    input  logic       eq,
    output logic       fire,
    output cmp_state_e state
);
    cmp_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (armable) state_nx = ST_ARMED;          // T_ENABLE
            end
            ST_ARMED: begin
                if (!armable) state_nx = ST_OFF;           // T_DISABLE
                else if (eq) begin
                    state_nx = ST_HELD;                    // T_FIRE
                    fire     = 1'b1;
                end
            end
            ST_HELD: begin
                if (!armable) state_nx = ST_OFF;           // T_DISABLE
                else if (!eq) state_nx = ST_ARMED;         // T_REARM
            end
            default: state_nx = ST_OFF;
        endcase
    end
endmodule

// File: rtl/cmpo_latch.sv
module cmpo_latch
    import cmpo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fire,
    input  cmp_act_e act,
    input  logic     force_low,
    input  logic     flag_clr,
    output logic     out_latch,
    output logic     irq_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_latch <= 1'b0;
        end else if (force_low) begin
            out_latch <= 1'b0;
        end else if (fire) begin
            case (act)
                ACT_HIGH:   out_latch <= 1'b1;
                ACT_LOW:    out_latch <= 1'b0;
                ACT_TOGGLE: out_latch <= ~out_latch;
                default:    out_latch <= out_latch;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (fire)     irq_flag <= 1'b1;
        else if (flag_clr) irq_flag <= 1'b0;
    end
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
    import cmpo_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      timer_val,
    input  logic              cmp_wr_en,
    input  logic [W-1:0]      cmp_wr_data,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_data,
    input  logic              flag_clr,
    output logic              out_latch,
    output logic              irq_flag
);
    logic [W-1:0]      cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic              eq;
    logic              fire;
    logic              force_low;
    cmp_act_e          act;
    cmp_state_e        state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= MODE_OFF;
        end else begin
            if (cmp_wr_en)  cmp_q  <= cmp_wr_data;
            if (mode_wr_en) mode_q <= mode_wr_data;
        end
    end

    assign act       = decode_mode(mode_q);
    assign force_low = mode_wr_en && (mode_wr_data == MODE_OFF);

    cmpo_match #(.W(W)) u_match (
        .cmp_val (cmp_q),
        .tmr_val (timer_val),
        .eq      (eq)
    );

    cmpo_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .armable (act != ACT_NONE),
        .eq      (eq),
        .fire    (fire),
        .state   (state)
    );

    cmpo_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .act       (act),
        .force_low (force_low),
        .flag_clr  (flag_clr),
        .out_latch (out_latch),
        .irq_flag  (irq_flag)
    );
endmodule

// File: rtl/cmpo_checker.sv
module cmpo_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr_en,
    input logic [3:0] mode_wr_data,
    input logic       flag_clr,
    input logic       fire,
    input logic [3:0] mode_q,
    input logic       out_latch,
    input logic       irq_flag
);
    p_fire_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq_flag);

    p_high_drives_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_q == 4'b1000 && !mode_wr_en) |=> out_latch);

    p_irq_only_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_q == 4'b1010 && !mode_wr_en) |=> $stable(out_latch));

    p_zero_forces_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_en && mode_wr_data == 4'b0000) |=> !out_latch);

    p_single_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fire) |=> !irq_flag);

    p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3:2] != 2'b10) |-> !fire);
endmodule

bind cmp_out_unit cmpo_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .flag_clr     (flag_clr),
    .fire         (fire),
    .mode_q       (mode_q),
    .out_latch    (out_latch),
    .irq_flag     (irq_flag)
);

// File: tb/tb_cmp_out_unit.sv
`timescale 1ns/1ps
module tb_cmp_out_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic        cmp_wr_en = 1'b0;
    logic [15:0] cmp_wr_data = '0;
    logic        mode_wr_en = 1'b0;
    logic [3:0]  mode_wr_data = '0;
    logic        flag_clr = 1'b0;
    logic        out_latch;
    logic        irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  eo;
        logic  ef;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    cmp_out_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .timer_val    (timer_val),
        .cmp_wr_en    (cmp_wr_en),
        .cmp_wr_data  (cmp_wr_data),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .flag_clr     (flag_clr),
        .out_latch    (out_latch),
        .irq_flag     (irq_flag)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus plus the outputs expected after its edge
    task automatic step(input logic [15:0] t, input logic cw, input logic [15:0] cd,
                        input logic mw, input logic [3:0] md, input logic clr,
                        input logic eo, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        timer_val    = t;
        cmp_wr_en    = cw;
        cmp_wr_data  = cd;
        mode_wr_en   = mw;
        mode_wr_data = md;
        flag_clr     = clr;
        e.eo = eo; e.ef = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(out_latch, e.eo, {e.tag, " out_latch"});
                check(irq_flag,  e.ef, {e.tag, " irq_flag"});
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_latch, 1'b0, "R1 reset out_latch");
        check(irq_flag,  1'b0, "R1 reset irq_flag");
        @(negedge clk);
        rst_n = 1'b1;

        //    timer    cw cd        mw md       clr  out flag tag
        step(16'd5,    0, 16'h0,    1, 4'b1000, 0,   0, 0, "R8 mode write, not armed");
        step(16'd5,    0, 16'h0,    0, 4'b0000, 0,   0, 0, "R8 arming edge");
        step(16'd0,    0, 16'h0,    0, 4'b0000, 0,   1, 1, "R1 R3 reset compare 0 matches, high");
        step(16'd0,    0, 16'h0,    0, 4'b0000, 0,   1, 1, "R6 held equality");
        step(16'd1,    0, 16'h0,    0, 4'b0000, 1,   1, 0, "R7 clear flag");
        step(16'd1,    1, 16'h1234, 0, 4'b0000, 0,   1, 0, "R2 compare write");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 1, "R2 new compare value matches");
        step(16'h1234, 0, 16'h0,    1, 4'b1001, 0,   1, 1, "R6 no refire on mode change while equal");
        step(16'h1235, 0, 16'h0,    0, 4'b0000, 1,   1, 0, "R6 rearm and clear");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 1,   0, 1, "R3 R7 drive low, set beats clear");
        step(16'h1233, 0, 16'h0,    1, 4'b1011, 1,   0, 0, "R7 clear");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 1, "R3 toggle to one");
        step(16'h1235, 0, 16'h0,    0, 4'b0000, 0,   1, 1, "R7 flag sticky");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   0, 1, "R3 toggle to zero");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   0, 1, "R6 no second toggle");
        step(16'h1235, 0, 16'h0,    0, 4'b0000, 0,   0, 1, "R6 rearm");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 1, "R3 toggle to one again");
        step(16'h1235, 0, 16'h0,    1, 4'b1010, 1,   1, 0, "R4 select interrupt only");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 1, "R4 flag set, pin unchanged");
        step(16'h1235, 0, 16'h0,    0, 4'b0000, 1,   1, 0, "R7 clear");
        step(16'h1235, 0, 16'h0,    1, 4'b0000, 0,   0, 0, "R5 zero mode forces low");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   0, 0, "R8 off mode no action");
        step(16'h1235, 0, 16'h0,    1, 4'b1000, 0,   0, 0, "R8 mode write");
        step(16'h1235, 0, 16'h0,    0, 4'b0000, 0,   0, 0, "R8 arming edge");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 1, "R3 drive high");
        step(16'h1234, 0, 16'h0,    1, 4'b0000, 0,   0, 1, "R5 force low, flag kept");
        step(16'h1235, 0, 16'h0,    1, 4'b1000, 1,   0, 0, "R8 rewrite compare mode");
        step(16'h1235, 0, 16'h0,    0, 4'b0000, 0,   0, 0, "R8 arming edge");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 1, "R3 drive high");
        step(16'h1235, 0, 16'h0,    1, 4'b0101, 1,   1, 0, "R8 undefined code keeps latch");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 0, "R8 undefined code no action");
        step(16'h1234, 0, 16'h0,    0, 4'b0000, 0,   1, 0, "R8 undefined code still silent");

        @(negedge clk);
        mode_wr_en = 1'b0;
        flag_clr   = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule